// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of a two-wire serial memory with a 17-bit byte address. It runs on a fast system clock. It synchronises the raw SCL and SDA lines and watches them for start and stop conditions. It then decodes the transfers that follow: byte writes and sequential reads against an internal byte store. The block only ever pulls SDA low, through an output enable. An external pull-up and the bus wiring form the open-drain line.

A write transfer is made of four bytes: a device byte, the two lower address bytes, and one data byte. The data byte is held in a one-entry buffer and committed to the store when the stop condition arrives. The commit starts an internal write cycle, modelled by a cycle counter. While that cycle runs, the device byte is refused, so a master can poll for completion. A read transfer returns bytes from an internal address pointer, most significant bit first, and continues for as long as the master acknowledges.

The protocol address is always 17 bits and wraps at 2^17. The physical store holds 2^STORE_AW bytes and is indexed by the low STORE_AW address bits, so higher addresses alias onto it.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high starts a transfer, from any state. A rising SDA while SCL is high ends it. After a stop, `standby` is high whenever no write cycle is running, and it is also high after reset.
- R2: The device byte is laid out as bits [7:2] = DEV_ID, bit 1 = address bit 16, and bit 0 = direction (1 = read). If bits [7:2] do not match, the byte is not acknowledged and every later byte is ignored until the next start.
- R3: For every byte it accepts, the slave pulls SDA low for the whole ninth SCL clock. At all other times outside its own read data, SDA is released.
- R4: In a write transfer, the two bytes after the device byte carry address bits 15..8 and then 7..0. Each is acknowledged, and together with bit 1 of the device byte they form the 17-bit address.
- R5: The first data byte of a write is acknowledged and stored at the addressed location only when a stop follows. Any further data byte in the same transfer is not acknowledged and is discarded.
- R6: A repeated start that arrives before the stop discards the buffered data byte. The store is unchanged and no write cycle begins.
- R7: A committing stop raises `write_busy` for exactly WRITE_CYCLES system clocks. While it is raised, `standby` is low.
- R8: While `write_busy` is high, a matching device byte is not acknowledged. Once `write_busy` falls, the same byte is acknowledged.
- R9: In a read, each byte is driven MSB first, and SDA changes only while SCL is low. After each byte the pointer advances by one. A master acknowledge makes the slave send the next byte. A master non-acknowledge makes the slave release SDA and ignore the bus until the next start or stop.
- R10: A write header followed by a repeated start and a read device byte returns data starting at the address in that header.
- R11: The address pointer wraps from 0x1FFFF to 0x00000 during sequential reads.
- R12: After a committed write to address A, a read that sends no address starts at A+1.
- R13: The slave changes its SDA output enable only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| standby | output | 1 | No transfer in progress and no write cycle running |
| write_busy | output | 1 | Internal write cycle in progress |

## Verification
The assertions assume that SCL stays at each level for longer than the synchroniser and edge-detector latency of a few system clocks. They also assume that the master changes SDA only well inside the SCL low phase, and never issues a start or stop while the slave is pulling the line low. The stimulus respects both: each SCL quarter period lasts ten system clocks, the master's data moves one quarter after each falling SCL edge, and every start and stop is issued after the slave has released the line.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

  // Protocol phase of the slave.
  typedef enum logic [2:0] {
    PH_IDLE,  // standby, waiting for a start
    PH_RX,    // shifting in a byte from the master
    PH_ACK,   // ninth clock after a received byte
    PH_TX,    // shifting out a read byte
    PH_MACK,  // ninth clock after a sent byte, master answers
    PH_SKIP   // not addressed or finished, wait for start or stop
  } phase_t;

  // Meaning of the byte currently being received.
  typedef enum logic [1:0] {
    RX_DEV,
    RX_AHI,
    RX_ALO,
    RX_DATA
  } rxkind_t;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  // pipe[i][1] is SCL, pipe[i][0] is SDA; idle bus is high.
  logic [1:0] pipe [STAGES];
  logic [1:0] last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= 2'b11;
        else        pipe[i] <= {scl_in, sda_in};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= 2'b11;
        else        pipe[i] <= pipe[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 2'b11;
    else        last_q <= pipe[STAGES-1];
  end

  logic scl_now, sda_now;
  assign scl_now   = pipe[STAGES-1][1];
  assign sda_now   = pipe[STAGES-1][0];
  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~last_q[1];
  assign scl_fall  = ~scl_now & last_q[1];
  assign bus_start = scl_now & last_q[1] & last_q[0] & ~sda_now;
  assign bus_stop  = scl_now & last_q[1] & ~last_q[0] & sda_now;

endmodule

// File: rtl/tw_byte_store.sv
module tw_byte_store #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/tw_write_timer.sv
module tw_write_timer #(
  parameter int CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left_q, left_d;
  logic          busy_q, busy_d;

  always_comb begin
    left_d = left_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      left_d = CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (left_q == '0) busy_d = 1'b0;
      else              left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_eeprom_pkg::*;
#(
  parameter logic [5:0] DEV_ID       = 6'b101000,
  parameter int         STORE_AW     = 11,
  parameter int         WRITE_CYCLES = 1000000,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe,
  output logic standby,
  output logic write_busy
);

  localparam int ADDR_W = 17;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  phase_t              ph_q, ph_d;
  rxkind_t             kind_q, kind_d;
  logic [3:0]          bitcnt_q, bitcnt_d;
  logic [7:0]          shreg_q, shreg_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                oe_q, oe_d;
  logic [7:0]          txb_q, txb_d;
  logic                rnw_q, rnw_d;
  logic                mnack_q, mnack_d;
  logic                pend_v_q, pend_v_d;
  logic [STORE_AW-1:0] pend_a_q, pend_a_d;
  logic [7:0]          pend_dat_q, pend_dat_d;
  logic [7:0]          rd_data;
  logic                mem_we;
  logic                load_rd;

  assign mem_we = bus_stop & pend_v_q;

  tw_byte_store #(.AW(STORE_AW)) u_store (
    .clk  (clk),
    .we   (mem_we),
    .waddr(pend_a_q),
    .wdata(pend_dat_q),
    .raddr(addr_q[STORE_AW-1:0]),
    .rdata(rd_data)
  );

  tw_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_core_n),
    .start(mem_we),
    .busy (write_busy)
  );

  // Next-state logic
  always_comb begin
    ph_d       = ph_q;
    kind_d     = kind_q;
    bitcnt_d   = bitcnt_q;
    shreg_d    = shreg_q;
    addr_d     = addr_q;
    oe_d       = oe_q;
    txb_d      = txb_q;
    rnw_d      = rnw_q;
    mnack_d    = mnack_q;
    pend_v_d   = pend_v_q;
    pend_a_d   = pend_a_q;
    pend_dat_d = pend_dat_q;
    load_rd    = 1'b0;

    if (bus_start) begin
      ph_d     = PH_RX;
      kind_d   = RX_DEV;
      bitcnt_d = 4'd0;
      oe_d     = 1'b0;
      pend_v_d = 1'b0;             // repeated start drops a buffered byte
    end else if (bus_stop) begin
      ph_d     = PH_IDLE;
      oe_d     = 1'b0;
      pend_v_d = 1'b0;             // committed through mem_we this cycle
    end else begin
      case (ph_q)
        PH_RX: begin
          if (scl_rise) begin
            shreg_d  = {shreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            bitcnt_d = 4'd0;
            ph_d     = PH_ACK;
            oe_d     = 1'b1;
            case (kind_q)
              RX_DEV: begin
                if (shreg_q[7:2] != DEV_ID || write_busy) begin
                  ph_d = PH_SKIP;
                  oe_d = 1'b0;
                end else begin
                  rnw_d  = shreg_q[0];
                  kind_d = RX_AHI;
                  if (!shreg_q[0]) addr_d[ADDR_W-1] = shreg_q[1];
                end
              end
              RX_AHI: begin
                addr_d[15:8] = shreg_q;
                kind_d       = RX_ALO;
              end
              RX_ALO: begin
                addr_d[7:0] = shreg_q;
                kind_d      = RX_DATA;
              end
              default: begin
                if (pend_v_q) begin
                  ph_d = PH_SKIP;
                  oe_d = 1'b0;
                end else begin
                  pend_v_d   = 1'b1;
                  pend_a_d   = addr_q[STORE_AW-1:0];
                  pend_dat_d = shreg_q;
                  addr_d     = addr_q + 1'b1;
                end
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            if (rnw_q) begin
              load_rd = 1'b1;
            end else begin
              ph_d = PH_RX;
              oe_d = 1'b0;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              ph_d = PH_MACK;
              oe_d = 1'b0;
            end else begin
              bitcnt_d = bitcnt_q + 4'd1;
              txb_d    = {txb_q[6:0], 1'b0};
              oe_d     = ~txb_q[6];
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            mnack_d = sda_s;
          end else if (scl_fall) begin
            if (mnack_q) ph_d = PH_SKIP;
            else         load_rd = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (load_rd) begin
      ph_d     = PH_TX;
      bitcnt_d = 4'd0;
      txb_d    = rd_data;
      oe_d     = ~rd_data[7];
      addr_d   = addr_q + 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ph_q       <= PH_IDLE;
      kind_q     <= RX_DEV;
      bitcnt_q   <= 4'd0;
      shreg_q    <= 8'h00;
      addr_q     <= '0;
      oe_q       <= 1'b0;
      txb_q      <= 8'h00;
      rnw_q      <= 1'b0;
      mnack_q    <= 1'b0;
      pend_v_q   <= 1'b0;
      pend_a_q   <= '0;
      pend_dat_q <= 8'h00;
    end else begin
      ph_q       <= ph_d;
      kind_q     <= kind_d;
      bitcnt_q   <= bitcnt_d;
      shreg_q    <= shreg_d;
      addr_q     <= addr_d;
      oe_q       <= oe_d;
      txb_q      <= txb_d;
      rnw_q      <= rnw_d;
      mnack_q    <= mnack_d;
      pend_v_q   <= pend_v_d;
      pend_a_q   <= pend_a_d;
      pend_dat_q <= pend_dat_d;
    end
  end

  assign sda_oe  = oe_q;
  assign standby = (ph_q == PH_IDLE) && !write_busy;

endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk #(
  parameter int WRITE_CYCLES = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_oe,
  input logic standby,
  input logic write_busy,
  input logic bus_start,
  input logic bus_stop,
  input logic scl_rise,
  input logic scl_fall,
  input logic mem_we
);

  logic [31:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_len <= '0;
    else if (write_busy) busy_len <= busy_len + 32'd1;
    else                 busy_len <= '0;
  end

  assert_quiet_in_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !sda_oe);

  assert_bus_events_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_start, bus_stop, scl_rise, scl_fall}));

  assert_start_releases_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !sda_oe);

  assert_busy_follows_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_busy) |-> ($past(bus_stop) && $past(mem_we)));

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_busy) |-> (busy_len == WRITE_CYCLES));

  assert_no_ack_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    write_busy |-> !sda_oe);

  assert_drive_moves_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(bus_start || bus_stop)) |-> !$past(scl_in));

endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .sda_oe    (sda_oe),
  .standby   (standby),
  .write_busy(write_busy),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .mem_we    (mem_we)
);

// File: tb/tb_tw_eeprom_slave.sv
`timescale 1ns/1ps
module tb_tw_eeprom_slave;

  localparam int         WC = 2000;
  localparam logic [5:0] ID = 6'b101000;
  localparam int         Q  = 10;

  logic clk, rst_n, scl, tb_oe;
  logic sda_oe, standby, write_busy, sda;
  int   n_chk, n_fail, oe_bad;
  logic oe_prev;
  logic [7:0] rbuf [4];

  assign sda = ~(sda_oe | tb_oe);

  tw_eeprom_slave #(.DEV_ID(ID), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .sda_oe(sda_oe), .standby(standby), .write_busy(write_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // R13 monitor: output enable must not move while the bench holds SCL high
  initial begin oe_bad = 0; oe_prev = 1'b0; end
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe !== oe_prev && scl) oe_bad = oe_bad + 1;
      oe_prev = sda_oe;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic m_start();
    tb_oe = 1'b0; tick(Q); scl = 1'b1; tick(2*Q);
    tb_oe = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    tb_oe = 1'b1; tick(Q); scl = 1'b1; tick(2*Q);
    tb_oe = 1'b0; tick(2*Q);
  endtask

  task automatic m_wbit(input bit b);
    tb_oe = ~b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic m_rbit(output bit b);
    tb_oe = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    @(negedge clk); b = sda;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic m_send(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(b);
    ack = !b;
  endtask

  task automatic m_recv(input bit ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin m_rbit(b); d[i] = b; end
    m_wbit(!ack);
  endtask

  function automatic logic [7:0] devb(input bit a16, input bit rd);
    return {ID, a16, rd};
  endfunction

  task automatic header(input logic [16:0] a, output bit ok);
    bit k1, k2, k3;
    m_start();
    m_send(devb(a[16], 1'b0), k1);
    m_send(a[15:8], k2);
    m_send(a[7:0], k3);
    ok = k1 & k2 & k3;
  endtask

  task automatic wait_ready();
    while (write_busy) tick(1);
    tick(2);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    bit ok, k;
    header(a, ok);
    m_send(d, k);
    m_stop();
    wait_ready();
  endtask

  task automatic do_read(input logic [16:0] a, input int n);
    bit ok, k;
    header(a, ok);
    m_start();
    m_send(devb(1'b0, 1'b1), k);
    for (int i = 0; i < n; i++) m_recv(i != n - 1, rbuf[i]);
    m_stop();
  endtask

  task automatic t_reset();
    chk(standby == 1'b1, "R1 standby after reset", standby, 1);
    chk(write_busy == 1'b0, "R7 no write cycle after reset", write_busy, 0);
    chk(sda_oe == 1'b0, "R3 line released after reset", sda_oe, 0);
  endtask

  task automatic t_foreign_id();
    bit k;
    m_start();
    m_send({6'b110011, 2'b00}, k);
    chk(!k, "R2 foreign device byte not acknowledged", k, 0);
    m_send(8'h00, k);
    chk(!k, "R2 later byte ignored", k, 0);
    m_stop(); tick(4);
    chk(standby, "R1 standby after stop", standby, 1);
  endtask

  task automatic t_write_basic();
    bit ok, k;
    int len;
    header(17'h00123, ok);
    chk(ok, "R4 device and address bytes acknowledged", ok, 1);
    m_send(8'hA5, k);
    chk(k, "R5 first data byte acknowledged", k, 1);
    m_stop();
    chk(write_busy, "R7 write cycle running after stop", write_busy, 1);
    chk(!standby, "R7 standby low during write cycle", standby, 0);
    len = 0;
    while (write_busy && len < 10*WC) begin @(negedge clk); if (write_busy) len++; end
    chk(len >= WC - 25 && len <= WC - 10, "R7 write cycle length", len, WC - 17);
    tick(4);
    chk(standby, "R1 standby after write cycle", standby, 1);
    do_read(17'h00123, 1);
    chk(rbuf[0] == 8'hA5, "R10 random read of written byte", rbuf[0], 8'hA5);
  endtask

  task automatic t_poll();
    bit ok, k;
    header(17'h00200, ok);
    m_send(8'h5A, k);
    m_stop();
    m_start();
    m_send(devb(1'b0, 1'b0), k);
    chk(!k, "R8 device byte refused while busy", k, 0);
    m_stop();
    wait_ready();
    m_start();
    m_send(devb(1'b0, 1'b0), k);
    chk(k, "R8 device byte accepted after busy", k, 1);
    m_stop(); tick(4);
  endtask

  task automatic t_discard();
    bit ok, k;
    do_write(17'h00300, 8'hAA);
    header(17'h00300, ok);
    m_send(8'h55, k);
    m_start();
    m_stop(); tick(4);
    chk(!write_busy, "R6 no write cycle after repeated start", write_busy, 0);
    do_read(17'h00300, 1);
    chk(rbuf[0] == 8'hAA, "R6 store unchanged", rbuf[0], 8'hAA);
  endtask

  task automatic t_extra_data();
    bit ok, k;
    do_write(17'h00401, 8'h99);
    header(17'h00400, ok);
    m_send(8'h11, k);
    m_send(8'h22, k);
    chk(!k, "R5 second data byte not acknowledged", k, 0);
    m_stop();
    wait_ready();
    do_read(17'h00400, 2);
    chk(rbuf[0] == 8'h11, "R5 first data byte stored", rbuf[0], 8'h11);
    chk(rbuf[1] == 8'h99, "R5 second data byte discarded", rbuf[1], 8'h99);
  endtask

  task automatic t_seq_read();
    bit ok, k;
    do_write(17'h00500, 8'h01);
    do_write(17'h00501, 8'h82);
    do_write(17'h00502, 8'hF3);
    header(17'h00500, ok);
    m_start();
    m_send(devb(1'b0, 1'b1), k);
    chk(k, "R9 read device byte acknowledged", k, 1);
    for (int i = 0; i < 3; i++) m_recv(i != 2, rbuf[i]);
    tick(4);
    chk(sda_oe == 1'b0, "R9 line released after master NACK", sda_oe, 0);
    m_stop();
    chk(rbuf[0] == 8'h01, "R9 sequential byte 0", rbuf[0], 8'h01);
    chk(rbuf[1] == 8'h82, "R9 sequential byte 1", rbuf[1], 8'h82);
    chk(rbuf[2] == 8'hF3, "R9 sequential byte 2", rbuf[2], 8'hF3);
  endtask

  task automatic t_wrap();
    do_write(17'h1FFFF, 8'hC3);
    do_write(17'h00000, 8'h3C);
    do_read(17'h1FFFF, 2);
    chk(rbuf[0] == 8'hC3, "R11 top address byte", rbuf[0], 8'hC3);
    chk(rbuf[1] == 8'h3C, "R11 wrap to address zero", rbuf[1], 8'h3C);
  endtask

  task automatic t_current_read();
    bit k;
    logic [7:0] d;
    do_write(17'h12346, 8'h77);
    do_write(17'h12345, 8'h66);
    m_start();
    m_send(devb(1'b0, 1'b1), k);
    m_recv(1'b0, d);
    m_stop();
    chk(d == 8'h77, "R12 read without address starts after last write", d, 8'h77);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; scl = 1'b1; tb_oe = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_foreign_id();
    t_write_basic();
    t_poll();
    t_discard();
    t_extra_data();
    t_seq_read();
    t_wrap();
    t_current_read();
    tick(10);
    chk(oe_bad == 0, "R13 output enable moved while SCL high", oe_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule